// File: doc/BRIEF.md
# External Asynchronous Device Bus Controller

This block turns word requests from an on-chip port into timed cycles on an external asynchronous bus. The bus serves SRAM, flash, ROM and memory-mapped peripherals. The external side has a 26-bit address, a 16-bit data bus and six active-low chip selects. The internal side carries a 32-bit address, four byte enables, 32-bit write data and a read/write flag, with a valid/ready handshake. Each request gets one single-cycle response that carries read data and an error flag.

Every chip select owns an address window, given by an enable, a base and a mask. It also owns a 15-bit configuration word with these fields:
- device width
- strobe wait states
- recovery gap
- external-wait honouring
- write protection
- strobe style

A 32-bit request aimed at a narrow device is cut into two 16-bit or four 8-bit device cycles. Cycles whose bytes are all disabled are skipped. Read bytes are merged back into one word.

A transaction timer watches every external access. It aborts an access that hangs and issues a one-clock reset-request pulse.

Top module: `devbus_ctrl`

## Requirements
- R1: Chip select i matches when `cs_en[i]` is 1 and `((req_addr ^ base_i) & mask_i) == 0`. The base and mask of chip select i are `cs_base[32i+:32]` and `cs_mask[32i+:32]`. When several match, the lowest index wins. During the device cycles, only the winner's `ext_cs_n` bit is low, and `ext_addr[25:2]` equals `req_addr[25:2]`.
- R2: In each device cycle, the chip select and address are valid one clock before the strobe goes low. They are held one clock after it returns high. With external wait inactive, the strobe stays low for `wst + 1` clocks.
- R3: Field `w16` (config bit 0) selects the device width. When it is 1, the block runs up to two cycles, at `ext_addr[1:0]` = 0 then 2, carrying bytes 1:0 then 3:2 on `ext_dout[15:0]`. When it is 0, the block runs up to four cycles, at `ext_addr[1:0]` = 0,1,2,3, carrying byte k on `ext_dout[7:0]` with `ext_dout[15:8]` = 0.
- R4: A device cycle whose bytes all have their enable at 0 is not run. If all four enables are 0, the response comes back with no error, zero data and no external cycle.
- R5: Read data is assembled from the device cycles (16-bit devices fill two bytes per cycle from `ext_din[15:0]`, 8-bit devices one byte from `ext_din[7:0]`). Each byte whose enable is 0 returns 0. A write returns zero data.
- R6: The `recov` field (config bits 11:7) sets a recovery gap of that many clocks with all chip selects high. The gap follows every device cycle: between cycles, and before the response after the last one. A recovery of 0 keeps the chip select low across consecutive cycles. The response appears `recov + 1` clocks after the hold clock.
- R7: Field `xwait` (config bit 12) enables the external wait input. When it is 1, the strobe stays low while `ext_wait` is 1, beyond the `wst` field (config bits 6:1). When it is 0, `ext_wait` has no effect.
- R8: Field `wprot` (config bit 13) write-protects a chip select. A write to a protected chip select runs no external cycle and answers with `rsp_err` = 1. Reads are unaffected.
- R9: The timer counts the clocks of an access, starting at 0 in its first setup clock. If the count equals a nonzero `tmr_limit` while the access is still on the bus, the access is aborted. This also applies in its final hold clock. The response then has `rsp_err` = 1, and `rst_req` is high for exactly that one response clock.
- R10: A request that matches no chip select answers in the next clock with `rsp_err` = 1 and drives no chip select.
- R11: Field `ds_style` (config bit 14) selects the strobe style. When it is 0, `ext_rd_n` strobes reads and `ext_wr_n` strobes writes, and `ext_ds_n` stays high. When it is 1, `ext_ds_n` strobes both, `ext_rnw` is 0 during write cycles, and `ext_rd_n`/`ext_wr_n` stay high.
- R12: `req_ready` is high only when the block is idle. `rsp_valid` lasts exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_en | input | NCS | Window enable per chip select |
| cs_base | input | 32*NCS | Window base per chip select |
| cs_mask | input | 32*NCS | Window compare mask per chip select |
| cs_cfg | input | 15*NCS | Per-chip-select configuration word |
| tmr_limit | input | TW | Transaction timer limit, 0 disables |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Request byte address (word aligned use) |
| req_we | input | 1 | 1 for write |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Error: unmapped, protected or timed out |
| rsp_rdata | output | 32 | Read data |
| ext_addr | output | XAW | External address |
| ext_cs_n | output | NCS | Chip selects, active low |
| ext_rd_n | output | 1 | Read strobe (split style) |
| ext_wr_n | output | 1 | Write strobe (split style) |
| ext_ds_n | output | 1 | Data strobe (combined style) |
| ext_rnw | output | 1 | Direction, 0 for write (combined style) |
| ext_dout | output | 16 | Write data to bus |
| ext_doe | output | 1 | Write data drive enable |
| ext_din | input | 16 | Read data from bus |
| ext_wait | input | 1 | External wait, active high |
| rst_req | output | 1 | One-clock reset request on timeout |

## Verification
The transaction timer can expire in the same clock that an access would end on its own: the final hold clock. The bench provokes this by setting the limit exactly to the clock count of a single-cycle read on a 16-bit device (`wst + 2`). It then repeats the read with a limit one higher. The first must answer with an error and a reset-request pulse, and the second must answer cleanly with the merged data. A second such overlap comes from the external wait input, which the bench drives during every strobe. The strobe length must therefore follow either the wait-state count or the wait input, depending on the chip select's `xwait` field, and random traffic checks both outcomes.

// File: rtl/devbus_pkg.sv
package devbus_pkg;

  localparam int IAW = 32;
  localparam int XDW = 16;

  typedef struct packed {
    logic       ds_style;
    logic       wprot;
    logic       xwait;
    logic [4:0] recov;
    logic [5:0] wst;
    logic       w16;
  } cs_cfg_t;

  localparam int CFGW = $bits(cs_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STRB, ST_HOLD, ST_RECOV, ST_DONE
  } seq_st_t;

  // is device cycle k needed for these byte enables
  function automatic logic piece_on(input logic [3:0] be, input logic w16,
                                    input logic [1:0] k);
    if (w16) piece_on = !k[1] && (be[{k[0], 1'b0}] || be[{k[0], 1'b1}]);
    else     piece_on = be[k];
  endfunction

  // lowest needed piece at index >= from; bit 2 set when none remains
  function automatic logic [2:0] seek_piece(input logic [3:0] be, input logic w16,
                                            input logic [2:0] from);
    logic [2:0] r;
    r = 3'b100;
    for (int i = 3; i >= 0; i--) begin
      if (i >= int'(from) && piece_on(be, w16, 2'(i))) r = {1'b0, 2'(i)};
    end
    return r;
  endfunction

  function automatic logic [1:0] lane_addr_lo(input logic w16, input logic [1:0] k);
    return w16 ? {k[0], 1'b0} : k;
  endfunction

  function automatic logic [XDW-1:0] wr_lane(input logic [31:0] wd, input logic w16,
                                             input logic [1:0] k);
    if (w16) return wd[{k[0], 4'b0000} +: 16];
    else     return {8'h00, wd[{k, 3'b000} +: 8]};
  endfunction

  function automatic logic [31:0] merge_rd(input logic [31:0] acc, input logic [XDW-1:0] din,
                                           input logic w16, input logic [1:0] k);
    logic [31:0] r;
    r = acc;
    if (w16) r[{k[0], 4'b0000} +: 16] = din;
    else     r[{k, 3'b000} +: 8] = din[7:0];
    return r;
  endfunction

  function automatic logic [31:0] mask_bytes(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? d[8*b +: 8] : 8'h00;
    return r;
  endfunction

endpackage

// File: rtl/devbus_decode.sv
module devbus_decode
  import devbus_pkg::*;
#(
  parameter int NCS = 6
) (
  input  logic [IAW-1:0]      addr,
  input  logic [NCS-1:0]      cs_en,
  input  logic [IAW*NCS-1:0]  cs_base,
  input  logic [IAW*NCS-1:0]  cs_mask,
  input  logic [CFGW*NCS-1:0] cs_cfg,
  output logic [NCS-1:0]      hit_oh,
  output logic                miss,
  output cs_cfg_t             sel_cfg
);

  logic [NCS-1:0] raw_hit;
  cs_cfg_t        cfg_arr [NCS];

  for (genvar i = 0; i < NCS; i++) begin : g_win
    assign raw_hit[i] = cs_en[i] &&
      (((addr ^ cs_base[i*IAW +: IAW]) & cs_mask[i*IAW +: IAW]) == '0);
    assign cfg_arr[i] = cs_cfg_t'(cs_cfg[i*CFGW +: CFGW]);
  end

  // lowest index wins: scanned downward so it is assigned last
  always_comb begin
    hit_oh  = '0;
    miss    = 1'b1;
    sel_cfg = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        hit_oh    = '0;
        hit_oh[i] = 1'b1;
        miss      = 1'b0;
        sel_cfg   = cfg_arr[i];
      end
    end
  end

endmodule

// File: rtl/devbus_wdog.sv
module devbus_wdog #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [TW-1:0] limit,
  output logic          expire,
  output logic          rst_pulse
);

  logic [TW-1:0] cnt;

  assign expire = busy && (limit != '0) && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= expire;
      if (!busy)          cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse) else $error("reset request wider than one clock"); // R9

endmodule

// File: rtl/devbus_seq.sv
module devbus_seq
  import devbus_pkg::*;
#(
  parameter int NCS = 6,
  parameter int XAW = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XAW-1:2]  req_waddr,
  input  logic            req_we,
  input  logic [3:0]      req_be,
  input  logic [31:0]     req_wdata,
  input  logic [NCS-1:0]  hit_oh,
  input  logic            miss,
  input  cs_cfg_t         sel_cfg,
  input  logic            expire,
  input  logic [XDW-1:0]  ext_din,
  input  logic            ext_wait,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [31:0]     rsp_rdata,
  output logic            busy,
  output logic            bus_cyc,
  output logic            strb_on,
  output logic            cyc_we,
  output logic            cyc_style,
  output logic [NCS-1:0]  cyc_cs,
  output logic [XAW-1:0]  ext_addr,
  output logic [XDW-1:0]  ext_dout
);

  seq_st_t        st;
  logic [XAW-1:2] r_wa;
  logic           r_we;
  logic [3:0]     r_be;
  logic [31:0]    r_wd;
  cs_cfg_t        r_cfg;
  logic [NCS-1:0] r_csoh;
  logic [1:0]     r_k;
  logic [5:0]     r_wc;
  logic [4:0]     r_rc;
  logic [31:0]    r_rd;
  logic           r_err;

  // named internal events
  logic       acc, wp_block, strb_done, rec_last;
  logic [2:0] first_pc, next_pc;

  assign acc       = req_valid && (st == ST_IDLE);
  assign wp_block  = req_we && sel_cfg.wprot;
  assign first_pc  = seek_piece(req_be, sel_cfg.w16, 3'd0);
  assign next_pc   = seek_piece(r_be, r_cfg.w16, {1'b0, r_k} + 3'd1);
  assign strb_done = (r_wc >= r_cfg.wst) && !(r_cfg.xwait && ext_wait);
  assign rec_last  = (r_rc == r_cfg.recov - 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      r_wa   <= '0;
      r_we   <= 1'b0;
      r_be   <= '0;
      r_wd   <= '0;
      r_cfg  <= '0;
      r_csoh <= '0;
      r_k    <= '0;
      r_wc   <= '0;
      r_rc   <= '0;
      r_rd   <= '0;
      r_err  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          r_wa   <= req_waddr;
          r_we   <= req_we;
          r_be   <= req_be;
          r_wd   <= req_wdata;
          r_cfg  <= sel_cfg;
          r_csoh <= hit_oh;
          r_rd   <= '0;
          r_k    <= first_pc[1:0];
          r_err  <= miss || wp_block;
          st     <= (miss || wp_block || first_pc[2]) ? ST_DONE : ST_SETUP;
        end
        ST_SETUP: begin
          r_wc <= '0;
          st   <= ST_STRB;
        end
        ST_STRB: begin
          if (strb_done) begin
            if (!r_we) r_rd <= merge_rd(r_rd, ext_din, r_cfg.w16, r_k);
            st <= ST_HOLD;
          end else if (r_wc != 6'h3f) begin
            r_wc <= r_wc + 6'd1;
          end
        end
        ST_HOLD: begin
          if (r_cfg.recov != 5'd0) begin
            r_rc <= '0;
            st   <= ST_RECOV;
          end else if (next_pc[2]) begin
            st <= ST_DONE;
          end else begin
            r_k <= next_pc[1:0];
            st  <= ST_SETUP;
          end
        end
        ST_RECOV: begin
          if (!rec_last) begin
            r_rc <= r_rc + 5'd1;
          end else if (next_pc[2]) begin
            st <= ST_DONE;
          end else begin
            r_k <= next_pc[1:0];
            st  <= ST_SETUP;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      // timeout overrides whatever the access would do next
      if (expire) begin
        r_err <= 1'b1;
        st    <= ST_DONE;
      end
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st == ST_SETUP) || (st == ST_STRB) || (st == ST_HOLD) || (st == ST_RECOV);
  assign bus_cyc   = (st == ST_SETUP) || (st == ST_STRB) || (st == ST_HOLD);
  assign strb_on   = (st == ST_STRB);
  assign cyc_we    = r_we;
  assign cyc_style = r_cfg.ds_style;
  assign cyc_cs    = r_csoh;
  assign ext_addr  = {r_wa, lane_addr_lo(r_cfg.w16, r_k)};
  assign ext_dout  = wr_lane(r_wd, r_cfg.w16, r_k);
  assign rsp_valid = (st == ST_DONE);
  assign rsp_err   = r_err;
  assign rsp_rdata = r_err ? '0 : mask_bytes(r_rd, r_be);

  AST_MISS_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && miss) |=> (rsp_valid && rsp_err && !bus_cyc)) else $error("unmapped access misbehaved"); // R10
  AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    strb_on |-> !(r_we && r_cfg.wprot)) else $error("strobe on protected write"); // R8
  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("response held over two clocks"); // R12
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready) else $error("ready while access on bus"); // R12

endmodule

// File: rtl/devbus_ctrl.sv
module devbus_ctrl
  import devbus_pkg::*;
#(
  parameter int NCS = 6,
  parameter int XAW = 26,
  parameter int TW  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCS-1:0]      cs_en,
  input  logic [IAW*NCS-1:0]  cs_base,
  input  logic [IAW*NCS-1:0]  cs_mask,
  input  logic [CFGW*NCS-1:0] cs_cfg,
  input  logic [TW-1:0]       tmr_limit,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IAW-1:0]      req_addr,
  input  logic                req_we,
  input  logic [3:0]          req_be,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [31:0]         rsp_rdata,
  output logic [XAW-1:0]      ext_addr,
  output logic [NCS-1:0]      ext_cs_n,
  output logic                ext_rd_n,
  output logic                ext_wr_n,
  output logic                ext_ds_n,
  output logic                ext_rnw,
  output logic [XDW-1:0]      ext_dout,
  output logic                ext_doe,
  input  logic [XDW-1:0]      ext_din,
  input  logic                ext_wait,
  output logic                rst_req
);

  logic [NCS-1:0] hit_oh, cyc_cs;
  logic           miss, expire, busy, bus_cyc, strb_on, cyc_we, cyc_style;
  cs_cfg_t        sel_cfg;

  devbus_decode #(.NCS(NCS)) u_decode (
    .addr(req_addr), .cs_en(cs_en), .cs_base(cs_base), .cs_mask(cs_mask),
    .cs_cfg(cs_cfg), .hit_oh(hit_oh), .miss(miss), .sel_cfg(sel_cfg)
  );

  devbus_seq #(.NCS(NCS), .XAW(XAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_waddr(req_addr[XAW-1:2]), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .hit_oh(hit_oh), .miss(miss), .sel_cfg(sel_cfg),
    .expire(expire), .ext_din(ext_din), .ext_wait(ext_wait),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .busy(busy), .bus_cyc(bus_cyc), .strb_on(strb_on), .cyc_we(cyc_we),
    .cyc_style(cyc_style), .cyc_cs(cyc_cs), .ext_addr(ext_addr), .ext_dout(ext_dout)
  );

  devbus_wdog #(.TW(TW)) u_wdog (
    .clk(clk), .rst_n(rst_n), .busy(busy), .limit(tmr_limit),
    .expire(expire), .rst_pulse(rst_req)
  );

  // pin formation by strobe style
  assign ext_cs_n = bus_cyc ? ~cyc_cs : '1;
  assign ext_rd_n = !(strb_on && !cyc_style && !cyc_we);
  assign ext_wr_n = !(strb_on && !cyc_style && cyc_we);
  assign ext_ds_n = !(strb_on && cyc_style);
  assign ext_rnw  = !(bus_cyc && cyc_style && cyc_we);
  assign ext_doe  = bus_cyc && cyc_we;

  logic strb_any;
  assign strb_any = !ext_rd_n || !ext_wr_n || !ext_ds_n;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n)) else $error("several chip selects low"); // R1
  AST_SETUP_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_any) |-> ($past(ext_cs_n) == ext_cs_n && $past(ext_addr) == ext_addr))
    else $error("no setup clock before strobe"); // R2
  AST_HOLD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strb_any) && !rsp_valid) |-> (ext_cs_n == $past(ext_cs_n) && ext_cs_n != '1))
    else $error("no hold clock after strobe"); // R2
  AST_TMO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rsp_valid && rsp_err)) else $error("reset request without error response"); // R9
  AST_STYLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((!ext_rd_n || !ext_wr_n) && !ext_ds_n)) else $error("both strobe styles active"); // R11

endmodule

// File: tb/devbus_ctrl_tb.sv
module devbus_ctrl_tb;
  localparam int NCS = 6;
  localparam int CW  = 15;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [NCS-1:0]    cs_en;
  logic [32*NCS-1:0] cs_base, cs_mask;
  logic [CW*NCS-1:0] cs_cfg;
  logic [15:0]       tmr_limit;
  logic              req_valid, req_ready, req_we;
  logic [31:0]       req_addr, req_wdata;
  logic [3:0]        req_be;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [25:0]       ext_addr;
  logic [NCS-1:0]    ext_cs_n;
  logic              ext_rd_n, ext_wr_n, ext_ds_n, ext_rnw, ext_doe, ext_wait, rst_req;
  logic [15:0]       ext_dout, ext_din;

  devbus_ctrl #(.NCS(NCS), .XAW(26), .TW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .cs_base(cs_base), .cs_mask(cs_mask),
    .cs_cfg(cs_cfg), .tmr_limit(tmr_limit), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_ds_n(ext_ds_n), .ext_rnw(ext_rnw), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din), .ext_wait(ext_wait), .rst_req(rst_req)
  );

  int nchk = 0, nfail = 0;
  int b_w16 [NCS], b_wst [NCS], b_rec [NCS], b_xw [NCS], b_wp [NCS], b_ds [NCS];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_rd(input int cs, input logic [25:0] a);
    return (a[15:0] * 16'h0329) ^ 16'(cs * 16'h1111) ^ 16'h5A0F;
  endfunction

  always_comb begin
    ext_din = '0;
    for (int i = 0; i < NCS; i++) if (!ext_cs_n[i]) ext_din = dev_rd(i, ext_addr);
  end

  task automatic apply_cfg();
    for (int i = 0; i < NCS; i++)
      cs_cfg[i*CW +: CW] = {b_ds[i][0], b_wp[i][0], b_xw[i][0], b_rec[i][4:0], b_wst[i][5:0], b_w16[i][0]};
  endtask

  task automatic default_windows();
    cs_en = '1;
    for (int i = 0; i < NCS; i++) begin
      cs_base[i*32 +: 32] = 32'(i) << 26;
      cs_mask[i*32 +: 32] = 32'hFC00_0000;
    end
  endtask

  // bus monitor, sampled away from the active edge
  int          tick = 0, mon_n = 0, slen = 0, gapc = 0, hold_n = 0, rsp_t = 0, stuck = 0;
  bit          in_strb = 0, rsp_seen = 0;
  logic [25:0] m_addr [8];
  logic [NCS-1:0] m_csn [8];
  logic [15:0] m_dout [8];
  bit          m_rd [8], m_wr [8], m_ds [8], m_rnw [8], m_su [8], m_ho [8];
  int          m_len [8], m_gap [8], m_t0 [8], m_tend [8];
  logic [NCS-1:0] p_csn;
  logic [25:0] p_addr;
  logic        s_err, s_rst;
  logic [31:0] s_rd;

  always @(negedge clk) begin
    bit strb;
    tick++;
    strb = !ext_rd_n || !ext_wr_n || !ext_ds_n;
    if (strb && !in_strb) begin
      if (mon_n < 8) begin
        m_addr[mon_n] = ext_addr; m_csn[mon_n] = ext_cs_n; m_dout[mon_n] = ext_dout;
        m_rd[mon_n] = !ext_rd_n; m_wr[mon_n] = !ext_wr_n; m_ds[mon_n] = !ext_ds_n;
        m_rnw[mon_n] = ext_rnw; m_su[mon_n] = (p_csn == ext_cs_n) && (p_addr == ext_addr);
        m_gap[mon_n] = gapc; m_t0[mon_n] = tick;
      end
      gapc = 0; slen = 1; in_strb = 1;
    end else if (strb) begin
      slen++;
    end else if (in_strb) begin
      if (mon_n < 8) begin
        m_len[mon_n] = slen; m_tend[mon_n] = tick;
        m_ho[mon_n] = (ext_cs_n == p_csn) && (ext_addr == p_addr);
      end
      mon_n++; in_strb = 0;
    end
    if (ext_cs_n == '1) gapc++;
    ext_wait = (stuck != 0) || (strb && (slen - 1 < hold_n));
    if (rsp_valid) begin
      rsp_seen = 1; rsp_t = tick; s_err = rsp_err; s_rst = rst_req; s_rd = rsp_rdata;
    end
    p_csn = ext_cs_n; p_addr = ext_addr;
  end

  task automatic issue(input logic [31:0] a, input bit we, input logic [3:0] be,
                       input logic [31:0] wd, input int hold);
    int g = 0;
    hold_n = hold; mon_n = 0; rsp_seen = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = we; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_seen && g < 5000) begin @(negedge clk); g++; end
    check(rsp_seen, "R12 response arrives", 32'(rsp_seen), 1);
    @(negedge clk);
    check(!rsp_valid, "R12 response one clock", 32'(rsp_valid), 0);
  endtask

  function automatic int target(input logic [31:0] a);
    for (int i = 0; i < NCS; i++)
      if (cs_en[i] && (((a ^ cs_base[i*32 +: 32]) & cs_mask[i*32 +: 32]) == 0)) return i;
    return -1;
  endfunction

  // full access with expectations derived from the requirements
  task automatic run(input logic [31:0] a, input bit we, input logic [3:0] be,
                     input logic [31:0] wd, input int hold);
    int cs, np, hw;
    logic [31:0] exp_rd;
    issue(a, we, be, wd, hold);
    cs = target(a);
    if (cs < 0) begin
      check(s_err === 1'b1 && mon_n == 0, "R10 unmapped error", {s_err, 31'(mon_n)}, 32'h8000_0000);
      return;
    end
    if (we && b_wp[cs] != 0) begin
      check(s_err === 1'b1 && mon_n == 0, "R8 protected write", {s_err, 31'(mon_n)}, 32'h8000_0000);
      return;
    end
    check(s_err === 1'b0 && s_rst === 1'b0, "R9 no error on normal access", {30'b0, s_err, s_rst}, 0);
    np = 0; exp_rd = 0;
    hw = b_w16[cs] != 0 ? 2 : 4;
    for (int k = 0; k < hw; k++) begin
      bit on;
      logic [25:0] pa;
      logic [15:0] pd, din;
      int len;
      on = (hw == 2) ? (((be >> (2*k)) & 4'h3) != 0) : be[k];
      if (!on) continue;
      pa = {a[25:2], (hw == 2) ? 2'(2*k) : 2'(k)};
      pd = (hw == 2) ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
      din = dev_rd(cs, pa);
      if (hw == 2) begin
        if (be[2*k])   exp_rd[16*k +: 8]   = din[7:0];
        if (be[2*k+1]) exp_rd[16*k+8 +: 8] = din[15:8];
      end else if (be[k]) exp_rd[8*k +: 8] = din[7:0];
      len = (b_xw[cs] != 0 && hold > b_wst[cs]) ? hold + 1 : b_wst[cs] + 1;
      if (np < mon_n && np < 8) begin
        check(m_addr[np] == pa, "R3 cycle address", 32'(m_addr[np]), 32'(pa));
        check(m_csn[np] == ~(NCS'(1) << cs), "R1 chip select", 32'(m_csn[np]), 32'(~(NCS'(1) << cs)));
        check(m_len[np] == len, "R2 R7 strobe length", m_len[np], len);
        check(m_su[np] && m_ho[np], "R2 setup and hold", {m_su[np], m_ho[np]}, 3);
        if (we) check(m_dout[np] == pd, "R3 write lane", 32'(m_dout[np]), 32'(pd));
        if (b_ds[cs] != 0)
          check(m_ds[np] && !m_rd[np] && !m_wr[np] && m_rnw[np] == !we, "R11 combined strobe",
                {m_ds[np], m_rd[np], m_wr[np], m_rnw[np]}, {1'b1, 2'b00, !we});
        else
          check(!m_ds[np] && m_rd[np] == !we && m_wr[np] == we, "R11 split strobe",
                {m_ds[np], m_rd[np], m_wr[np]}, {1'b0, !we, we});
        if (np > 0) check(m_gap[np] == b_rec[cs], "R6 recovery gap", m_gap[np], b_rec[cs]);
      end
      np++;
    end
    check(mon_n == np, "R4 cycle count", mon_n, np);
    if (np > 0 && np <= 8)
      check(rsp_t - m_tend[np-1] == b_rec[cs] + 1, "R6 tail to response", rsp_t - m_tend[np-1], b_rec[cs] + 1);
    check(s_rd == (we ? 32'h0 : exp_rd), "R5 read merge", s_rd, we ? 32'h0 : exp_rd);
  endtask

  task automatic rand_cfg();
    for (int i = 0; i < NCS; i++) begin
      b_w16[i] = $urandom_range(0, 1); b_wst[i] = $urandom_range(0, 6);
      b_rec[i] = $urandom_range(0, 3); b_xw[i]  = $urandom_range(0, 1);
      b_wp[i]  = ($urandom_range(0, 7) == 0); b_ds[i] = $urandom_range(0, 1);
    end
    apply_cfg();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog act=%0d exp=%0d", tick, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_2024));
    rst_n = 0; req_valid = 0; req_addr = 0; req_we = 0; req_be = 0; req_wdata = 0;
    ext_wait = 0; tmr_limit = 16'd2000;
    default_windows();
    for (int i = 0; i < NCS; i++) begin
      b_w16[i] = 1; b_wst[i] = 1; b_rec[i] = 0; b_xw[i] = 0; b_wp[i] = 0; b_ds[i] = 0;
    end
    apply_cfg();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !rst_req && ext_cs_n == '1 && ext_rd_n && ext_wr_n && ext_ds_n,
          "R12 reset state", {req_ready, rsp_valid, rst_req, ext_rd_n, ext_wr_n, ext_ds_n}, 6'b100111);

    // directed: widths, styles and enables
    run(32'h0000_0010, 0, 4'hF, 0, 0);                    // R3 16-bit read
    b_w16[1] = 0; b_ds[1] = 1; b_rec[1] = 2; apply_cfg();
    run(32'h0400_0024, 1, 4'hF, 32'hA1B2_C3D4, 0);        // R3 R11 8-bit write
    run(32'h0400_0024, 0, 4'b1010, 0, 0);                 // R4 R5 sparse read
    run(32'h0400_0024, 0, 4'h0, 0, 0);                    // R4 no enables
    b_w16[2] = 1; b_xw[2] = 1; b_wst[2] = 2; apply_cfg();
    run(32'h0800_0100, 0, 4'b1100, 0, 7);                 // R7 wait stretches
    b_xw[2] = 0; apply_cfg();
    run(32'h0800_0100, 0, 4'b0011, 0, 7);                 // R7 wait ignored
    b_wp[3] = 1; apply_cfg();
    run(32'h0C00_0040, 1, 4'hF, 32'h1234_5678, 0);        // R8 blocked
    run(32'h0C00_0040, 0, 4'hF, 0, 0);                    // R8 read allowed
    b_wp[3] = 0; apply_cfg();
    run(32'hF000_0000, 0, 4'hF, 0, 0);                    // R10 unmapped
    b_w16[4] = 0; b_wst[4] = 63; b_rec[4] = 31; apply_cfg();
    run(32'h1000_0008, 1, 4'hF, 32'hCAFE_F00D, 0);        // R2 R6 extremes
    cs_base[3*32 +: 32] = cs_base[2*32 +: 32];
    run(32'h0800_0200, 0, 4'hF, 0, 0);                    // R1 lowest index wins
    default_windows();

    // R9 hung access: wait stuck high
    b_xw[0] = 1; b_w16[0] = 1; apply_cfg(); tmr_limit = 16'd40; stuck = 1;
    issue(32'h0000_0000, 0, 4'hF, 0, 0);
    check(s_err === 1'b1 && s_rst === 1'b1, "R9 timeout response", {s_err, s_rst}, 3);
    check(rsp_t - m_t0[0] == 40, "R9 timeout clock", rsp_t - m_t0[0], 40);
    check(s_rd == 0, "R9 timeout data", s_rd, 0);
    check(!rst_req && ext_cs_n == '1, "R9 pulse ends", {rst_req, ext_cs_n}, 7'h3F);
    stuck = 0; b_xw[0] = 0;

    // R9 expiry in the final hold clock versus one clock later
    b_w16[1] = 1; b_wst[1] = 5; b_rec[1] = 0; b_xw[1] = 0; b_ds[1] = 0; apply_cfg();
    tmr_limit = 16'd7;
    issue(32'h0400_0030, 0, 4'b0011, 0, 0);
    check(s_err === 1'b1 && s_rst === 1'b1, "R9 expiry at hold", {s_err, s_rst}, 3);
    tmr_limit = 16'd8;
    run(32'h0400_0030, 0, 4'b0011, 0, 0);
    tmr_limit = 16'd2000;

    // constrained random traffic
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a;
      if (n % 25 == 0) rand_cfg();
      a = {($urandom_range(0, 9) == 0) ? 6'd50 : 6'($urandom_range(0, NCS-1)), 26'($urandom) & 26'h3FF_FFFC};
      run(a, 1'($urandom_range(0, 1)), 4'($urandom), $urandom, $urandom_range(0, 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule